// File: doc/BRIEF.md
# Oscillator Source Switch Controller

This controller decides whether the system clock comes from the internal ring oscillator (about 1 MHz) or from the high-frequency source, which is either a crystal or a directly driven external clock. It holds the ring oscillator as the source while the high-frequency source warms up, and moves the source only when a warmup or delay count finishes. The warmup length depends on a strap that tells a crystal from an external clock. It also counts the ring-cycle delay that keeps reset asserted after power-on and after a wake from stop. The analog oscillators and the glitch-free clock multiplexer sit outside this block. Each oscillator's activity arrives as a one-cycle tick strobe, sampled on a free-running control clock.

Software reaches the block through two write strobes. One sets the ring-select bit and the other sets the high-frequency disable bit. A single output, `sel_ring`, drives the clock multiplexer and also serves as the read-only mode bit: 1 means the ring oscillator is active and 0 means the high-frequency source is active.

Top module: `osc_src_switch`

## Requirements
- R1: While `por_n` is low, the outputs read `sel_ring`=1, `rst_hold`=1, `stopped`=0, `ring_sel`=0 and `hf_dis`=0.
- R2: After power-on, `rst_hold` falls on the 10th `ring_tick` sampled while `supply_ok` is 1. Ring ticks that arrive while `supply_ok` is 0 are not counted.
- R3: With `ext_clk_mode`=0, `sel_ring` stays 1 through 8191 `hf_tick` strobes and drops to 0 on the 8192nd.
- R4: With `ext_clk_mode`=1, the warmup is 10 `hf_tick` strobes.
- R5: Writing 1 to `ring_sel` while the high-frequency source is active raises `sel_ring` on the 10th following `ring_tick`.
- R6: A write of 1 to `hf_dis` takes effect only while `ring_sel` and `sel_ring` are both 1. Otherwise the write is ignored and `hf_dis` keeps its old value. A write of 0 is always accepted.
- R7: After `ring_sel` is cleared, `sel_ring` stays 1 until a full warmup completes. No warmup runs while `hf_dis` is 1.
- R8: A `stop_req` pulse sets `stopped`. While the block is stopped, `hf_tick` strobes do not advance the warmup, and the select output does not change.
- R9: A `stop_wake` pulse while stopped clears `stopped`, raises `rst_hold` and forces `sel_ring` to 1. `rst_hold` falls after 10 ring ticks. The warmup then restarts from zero, so any partial count made before stop is discarded.
- R10: `ring_sel` keeps its value across stop and wake, so the ring oscillator stays the source. Only `por_n` clears `ring_sel`.
- R11: When no `hf_tick` arrives, `sel_ring` stays 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply above the reset threshold |
| ring_tick | input | 1 | One strobe per ring oscillator cycle |
| hf_tick | input | 1 | One strobe per high-frequency source cycle |
| ext_clk_mode | input | 1 | 1 = external clock input, 0 = crystal |
| stop_req | input | 1 | Request to enter stop mode |
| stop_wake | input | 1 | Stop-exit event |
| rs_we | input | 1 | Write strobe for the ring-select bit |
| rs_wd | input | 1 | Ring-select write data |
| hd_we | input | 1 | Write strobe for the high-frequency disable bit |
| hd_wd | input | 1 | Disable bit write data |
| sel_ring | output | 1 | Source select and mode bit, 1 = ring oscillator |
| rst_hold | output | 1 | Reset held while the ring delay counts |
| stopped | output | 1 | Stop mode active |
| ring_sel | output | 1 | Ring-select bit readback |
| hf_dis | output | 1 | High-frequency disable bit readback |

## Verification
The hardest state to reach is a warmup that is cut off by stop and must then restart from zero. To create it, the stimulus starts a warmup with five external-clock ticks and enters stop. It delivers extra ticks while the block is stopped, then wakes the block and clears the ring delay. The bench then checks that `sel_ring` stays 1 after nine more ticks and falls on the tenth. The rule that ignores a write to the disable bit is tested in two ways: once with ring-select cleared, and once with ring-select set while the 10-tick switch delay to the ring oscillator is still pending.

// File: rtl/osc_src_switch.sv
module osc_src_switch #(
  parameter int RING_DLY  = 10,
  parameter int XTAL_WARM = 8192,
  parameter int EXT_WARM  = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic ring_tick,
  input  logic hf_tick,
  input  logic ext_clk_mode,
  input  logic stop_req,
  input  logic stop_wake,
  input  logic rs_we,
  input  logic rs_wd,
  input  logic hd_we,
  input  logic hd_wd,
  output logic sel_ring,
  output logic rst_hold,
  output logic stopped,
  output logic ring_sel,
  output logic hf_dis
);

  localparam int WMAX = (XTAL_WARM > EXT_WARM) ? XTAL_WARM : EXT_WARM;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int RW   = $clog2(RING_DLY + 1);

  logic [RW-1:0] rcnt;
  logic [WW-1:0] wcnt;

  wire sw_en   = !rst_hold && !stopped && ring_sel && !sel_ring;
  wire r_en    = (rst_hold && supply_ok) || sw_en;
  wire r_done  = r_en && ring_tick && (rcnt >= RW'(RING_DLY - 1));
  wire w_en    = !rst_hold && !stopped && !ring_sel && !hf_dis && sel_ring;
  wire [WW-1:0] w_lim = ext_clk_mode ? WW'(EXT_WARM - 1) : WW'(XTAL_WARM - 1);
  wire w_done  = w_en && hf_tick && (wcnt >= w_lim);
  wire hd_ok   = !hd_wd || (ring_sel && sel_ring);
  wire go_stop = stop_req && !rst_hold && !stopped;
  wire wake    = stopped && stop_wake;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        rcnt <= '0;
    else if (!r_en || r_done || wake)  rcnt <= '0;
    else if (ring_tick)                rcnt <= rcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        wcnt <= '0;
    else if (!w_en || w_done)          wcnt <= '0;
    else if (hf_tick)                  wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_hold <= 1'b1;
      stopped  <= 1'b0;
      sel_ring <= 1'b1;
      ring_sel <= 1'b0;
      hf_dis   <= 1'b0;
    end else begin
      if (wake)                       rst_hold <= 1'b1;
      else if (rst_hold && r_done)    rst_hold <= 1'b0;

      if (go_stop)                    stopped <= 1'b1;
      else if (wake)                  stopped <= 1'b0;

      if (wake)                       sel_ring <= 1'b1;
      else if (w_done)                sel_ring <= 1'b0;
      else if (sw_en && r_done)       sel_ring <= 1'b1;

      if (rs_we)                      ring_sel <= rs_wd;
      if (hd_we && hd_ok)             hf_dis   <= hd_wd;
    end
  end

  p_hold_on_ring_r2: assert property (@(posedge clk) disable iff (!por_n)
    rst_hold |-> sel_ring);
  p_to_hf_on_tick_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sel_ring) |-> $past(hf_tick) && !$past(ring_sel) && !$past(hf_dis));
  p_to_ring_cause_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_ring) |-> $past(ring_tick) || $past(stop_wake));
  p_dis_guard_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(hf_dis) |-> $past(ring_sel) && $past(sel_ring));
  p_stop_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stopped) |-> $past(stop_req) && !rst_hold);
  p_sel_kept_r10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ring_sel) |-> $past(rs_we));

endmodule

// File: tb/osc_src_switch_test.sv
`timescale 1ns/1ps
module osc_src_switch_test;
  logic clk = 0, por_n = 0, supply_ok = 0, ring_tick = 0, hf_tick = 0;
  logic ext_clk_mode = 0, stop_req = 0, stop_wake = 0;
  logic rs_we = 0, rs_wd = 0, hd_we = 0, hd_wd = 0;
  logic sel_ring, rst_hold, stopped, ring_sel, hf_dis;
  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct { string req; logic [4:0] exp; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  osc_src_switch uut (.clk(clk), .por_n(por_n), .supply_ok(supply_ok),
    .ring_tick(ring_tick), .hf_tick(hf_tick), .ext_clk_mode(ext_clk_mode),
    .stop_req(stop_req), .stop_wake(stop_wake), .rs_we(rs_we), .rs_wd(rs_wd),
    .hd_we(hd_we), .hd_wd(hd_wd), .sel_ring(sel_ring), .rst_hold(rst_hold),
    .stopped(stopped), .ring_sel(ring_sel), .hf_dis(hf_dis));

  // monitor: {sel_ring, rst_hold, stopped, ring_sel, hf_dis}
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it = q.pop_front();
      act = {sel_ring, rst_hold, stopped, ring_sel, hf_dis};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%b expected=%b", it.req, act, it.exp);
      end
    end
  end

  task automatic chk(string r, logic [4:0] e);
    item_t it;
    it.req = r; it.exp = e;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic ring_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 ring_tick = 1;
      @(posedge clk); #1 ring_tick = 0;
    end
  endtask

  task automatic hf_ticks(int n);
    @(posedge clk); #1 hf_tick = 1;
    repeat (n) @(posedge clk);
    #1 hf_tick = 0;
  endtask

  task automatic wr_rs(logic v);
    @(posedge clk); #1 rs_we = 1; rs_wd = v;
    @(posedge clk); #1 rs_we = 0;
  endtask

  task automatic wr_hd(logic v);
    @(posedge clk); #1 hd_we = 1; hd_wd = v;
    @(posedge clk); #1 hd_we = 0;
  endtask

  task automatic do_stop();
    @(posedge clk); #1 stop_req = 1;
    @(posedge clk); #1 stop_req = 0;
  endtask

  task automatic do_wake();
    @(posedge clk); #1 stop_wake = 1;
    @(posedge clk); #1 stop_wake = 0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1", 5'b11000);
    por_n = 1;
    ring_ticks(12);            chk("R2", 5'b11000);
    supply_ok = 1;
    ring_ticks(9);             chk("R2", 5'b11000);
    ring_ticks(1);             chk("R2", 5'b10000);
    repeat (50) @(posedge clk); #1;
    chk("R11", 5'b10000);
    hf_ticks(8191);            chk("R3", 5'b10000);
    hf_ticks(1);               chk("R3", 5'b00000);
    wr_rs(1);                  chk("R5", 5'b00010);
    wr_hd(1);                  chk("R6", 5'b00010);
    ring_ticks(9);             chk("R5", 5'b00010);
    ring_ticks(1);             chk("R5", 5'b10010);
    wr_hd(1);                  chk("R6", 5'b10011);
    hf_ticks(20);              chk("R6", 5'b10011);
    wr_rs(0);
    hf_ticks(20);              chk("R7", 5'b10001);
    wr_hd(0);                  chk("R6", 5'b10000);
    ext_clk_mode = 1;
    hf_ticks(9);               chk("R7", 5'b10000);
    hf_ticks(1);               chk("R4", 5'b00000);
    wr_hd(1);                  chk("R6", 5'b00000);
    wr_rs(1); ring_ticks(10);  chk("R5", 5'b10010);
    wr_rs(0);
    hf_ticks(5);
    do_stop();                 chk("R8", 5'b10100);
    hf_ticks(20);              chk("R8", 5'b10100);
    do_wake();                 chk("R9", 5'b11000);
    ring_ticks(9);             chk("R9", 5'b11000);
    ring_ticks(1);             chk("R9", 5'b10000);
    hf_ticks(9);               chk("R9", 5'b10000);
    hf_ticks(1);               chk("R9", 5'b00000);
    do_stop();                 chk("R8", 5'b00100);
    do_wake();                 chk("R9", 5'b11000);
    ring_ticks(10);
    hf_ticks(10);              chk("R4", 5'b00000);
    wr_rs(1); ring_ticks(10);
    do_stop();                 chk("R10", 5'b10110);
    do_wake();                 chk("R10", 5'b11010);
    ring_ticks(10);
    hf_ticks(20);              chk("R10", 5'b10010);
    @(posedge clk); #1 por_n = 0;
    @(posedge clk); #1;        chk("R10", 5'b11000);
    done = 1;
    report();
  end
endmodule